// File: doc/BRIEF.md
# Iterative Binary Ridge Thinning Engine

This block reduces the ridges of a binary picture to lines one pixel wide. The picture sits in an internal frame buffer. While the engine is idle, the host fills the buffer through a single-bit write port. The host then pulses `start`. The engine sweeps the whole frame over and over, using the classic two-subiteration parallel thinning rule. Each sweep decides whether to erase a ridge pixel by looking at its eight surrounding pixels.

Each sweep visits one pixel per clock. Erasures found during a sweep are collected in a second buffer and copied into the frame when the sweep ends. Every decision in a sweep therefore sees the frame as it stood when that sweep began. A pair of sweeps, one per subiteration, is repeated until a whole pair erases nothing. The engine then raises `done` and reports how many pairs it ran. The host reads the thinned picture back through a registered read port.

Frame width and height are parameters. The default is 32x32, which keeps the buffer small. A 256x256 frame is reached by setting the parameters.

Top module: `thin_engine`

## Requirements
- R1: Pixel address is row*IMG_W+col. A pixel bit of 0 is ridge and 1 is valley. While idle, a write with `wr_en` high stores `wr_data` at `wr_addr`. `rd_data` shows the pixel at `rd_addr` one clock after the address is presented. With no write, the idle frame does not change.
- R2: A `start` pulse seen while idle makes `busy` high and `done` low from the next clock.
- R3: A pixel is erased (set to 1) only if it is ridge, has 2 to 6 ridge neighbours, and has exactly one valley-to-ridge step in the clockwise ring N, NE, E, SE, S, SW, W, NW, N.
- R4: In the first subiteration of a pair, an erasure also needs a valley among {N, E, S} and a valley among {E, S, W}.
- R5: In the second subiteration of a pair, an erasure also needs a valley among {N, E, W} and a valley among {N, S, W}.
- R6: All decisions within one subiteration use the frame as it stood at the start of that subiteration. Erasures take effect together when the subiteration ends.
- R7: Neighbours that lie outside the frame count as valley.
- R8: The engine never turns a valley pixel into ridge.
- R9: `done` rises only after a full pair of subiterations erases nothing. `pass_cnt` then holds the number of pairs run, including that final pair. A new start clears `done` and `pass_cnt`.
- R10: Writes presented while `busy` is high have no effect on the frame.
- R11: After reset, `busy`, `done` and `pass_cnt` are 0 and every pixel reads as valley.
- R12: A frame with no ridge pixels finishes after exactly one pair and is returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Pixel write strobe (used only while idle) |
| wr_addr | input | ADDR_W | Pixel address for a write |
| wr_data | input | 1 | Pixel value to write (0 ridge, 1 valley) |
| rd_addr | input | ADDR_W | Pixel address for a read |
| rd_data | output | 1 | Pixel value, one clock after `rd_addr` |
| start | input | 1 | Begin thinning (accepted while idle) |
| busy | output | 1 | Engine is sweeping |
| done | output | 1 | Converged; stays high until the next start |
| pass_cnt | output | PASS_W | Number of subiteration pairs run |

## Verification
Several test images stress specific parts of the rule. A two-pixel-wide bar catches an engine that writes erasures straight into the live frame: such an engine erodes the bar from both sides and breaks it, where the parallel rule leaves a thin line. A fully ridge frame catches an engine that treats off-frame neighbours as ridge, because its border pixels would then survive. An isolated pixel and a short stub catch a wrong neighbour-count or step-count bound, because they would be wrongly erased. Writes injected during a run, a blank frame, and a re-run on an already thinned frame catch, in turn, a write port left open while busy, a wrong pair count, and an engine that stops after a single subiteration.

// File: rtl/thin_pkg.sv
package thin_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_COMMIT = 2'd2
    } thin_state_e;

    // Clockwise neighbour ring positions
    localparam int NB_N  = 0;
    localparam int NB_NE = 1;
    localparam int NB_E  = 2;
    localparam int NB_SE = 3;
    localparam int NB_S  = 4;
    localparam int NB_SW = 5;
    localparam int NB_W  = 6;
    localparam int NB_NW = 7;
    localparam int NB_CNT = 8;

    function automatic int nb_dr(input int k);
        case (k)
            0, 1, 7: return -1;
            2, 6:    return 0;
            default: return 1;
        endcase
    endfunction

    function automatic int nb_dc(input int k);
        case (k)
            0, 4:    return 0;
            1, 2, 3: return 1;
            default: return -1;
        endcase
    endfunction

endpackage

// File: rtl/thin_nbr_fetch.sv
module thin_nbr_fetch #(
    parameter int IMG_W = 32,
    parameter int IMG_H = 32,
    localparam int NPIX = IMG_W * IMG_H,
    localparam int AW   = $clog2(NPIX),
    localparam int RW   = $clog2(IMG_H),
    localparam int CW   = $clog2(IMG_W)
) (
    input  logic [NPIX-1:0] frame,
    input  logic [RW-1:0]   row,
    input  logic [CW-1:0]   col,
    output logic            center,
    output logic [AW-1:0]   ctr_idx,
    output logic [7:0]      nb
);
    always_comb begin
        ctr_idx = AW'(int'(row) * IMG_W + int'(col));
        center  = frame[ctr_idx];
    end

    for (genvar k = 0; k < thin_pkg::NB_CNT; k++) begin : g_nb
        localparam int DR = thin_pkg::nb_dr(k);
        localparam int DC = thin_pkg::nb_dc(k);
        logic bit_v;
        always_comb begin
            int rr;
            int cc;
            rr = int'(row) + DR;
            cc = int'(col) + DC;
            if (rr < 0 || rr >= IMG_H || cc < 0 || cc >= IMG_W) begin
                bit_v = 1'b1;                       // off-frame is valley (R7)
            end else begin
                bit_v = frame[AW'(rr * IMG_W + cc)];
            end
        end
        assign nb[k] = bit_v;
    end

endmodule

// File: rtl/thin_rule.sv
module thin_rule (
    input  logic       center,
    input  logic [7:0] nb,
    input  logic       phase,
    output logic       del
);
    import thin_pkg::*;

    logic [3:0] ridge_cnt;
    logic [3:0] step_cnt;
    logic       dir_ok;

    always_comb begin
        ridge_cnt = '0;
        step_cnt  = '0;
        for (int k = 0; k < NB_CNT; k++) begin
            ridge_cnt = ridge_cnt + {3'b000, ~nb[k]};
            step_cnt  = step_cnt + {3'b000, nb[k] & ~nb[(k + 1) % NB_CNT]};
        end
        if (!phase) begin
            dir_ok = (nb[NB_N] | nb[NB_E] | nb[NB_S]) &
                     (nb[NB_E] | nb[NB_S] | nb[NB_W]);
        end else begin
            dir_ok = (nb[NB_N] | nb[NB_E] | nb[NB_W]) &
                     (nb[NB_N] | nb[NB_S] | nb[NB_W]);
        end
        del = !center && (ridge_cnt >= 4'd2) && (ridge_cnt <= 4'd6) &&
              (step_cnt == 4'd1) && dir_ok;
    end

endmodule

// File: rtl/thin_ctrl.sv
module thin_ctrl #(
    parameter int IMG_W  = 32,
    parameter int IMG_H  = 32,
    parameter int PASS_W = 16,
    localparam int RW = $clog2(IMG_H),
    localparam int CW = $clog2(IMG_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              del_hit,
    output logic              scan,
    output logic              commit,
    output logic              busy,
    output logic              phase,
    output logic [RW-1:0]     row,
    output logic [CW-1:0]     col,
    output logic              done,
    output logic [PASS_W-1:0] pass_cnt
);
    import thin_pkg::*;

    typedef struct packed {
        thin_state_e       state;
        logic              phase;
        logic [RW-1:0]     row;
        logic [CW-1:0]     col;
        logic              pair_del;
        logic [PASS_W-1:0] pass_cnt;
        logic              done;
    } ctrl_s;

    ctrl_s q, d;

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.state    = ST_SCAN;
                    d.phase    = 1'b0;
                    d.row      = '0;
                    d.col      = '0;
                    d.pair_del = 1'b0;
                    d.pass_cnt = '0;
                    d.done     = 1'b0;
                end
            end
            ST_SCAN: begin
                if (del_hit) d.pair_del = 1'b1;
                if (q.col == CW'(IMG_W - 1)) begin
                    d.col = '0;
                    if (q.row == RW'(IMG_H - 1)) begin
                        d.row   = '0;
                        d.state = ST_COMMIT;
                    end else begin
                        d.row = q.row + 1'b1;
                    end
                end else begin
                    d.col = q.col + 1'b1;
                end
            end
            ST_COMMIT: begin
                if (!q.phase) begin
                    d.phase = 1'b1;
                    d.state = ST_SCAN;
                end else begin
                    d.pass_cnt = q.pass_cnt + 1'b1;
                    if (!q.pair_del) begin
                        d.state = ST_IDLE;
                        d.done  = 1'b1;
                    end else begin
                        d.phase    = 1'b0;
                        d.pair_del = 1'b0;
                        d.state    = ST_SCAN;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, phase: 1'b0, row: '0, col: '0,
                   pair_del: 1'b0, pass_cnt: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign scan     = (q.state == ST_SCAN);
    assign commit   = (q.state == ST_COMMIT);
    assign busy     = (q.state != ST_IDLE);
    assign phase    = q.phase;
    assign row      = q.row;
    assign col      = q.col;
    assign done     = q.done;
    assign pass_cnt = q.pass_cnt;

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.state == ST_IDLE)); // R9
    AST_DONE_AFTER_CLEAN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> ($past(q.phase) && !$past(q.pair_del))); // R9
    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && start) |=> (busy && !q.done && !q.phase && q.pass_cnt == '0)); // R2
    AST_PASS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (q.pass_cnt == $past(q.pass_cnt) || q.pass_cnt == $past(q.pass_cnt) + 1'b1)); // R9

endmodule

// File: rtl/thin_engine.sv
module thin_engine #(
    parameter int IMG_W  = 32,
    parameter int IMG_H  = 32,
    parameter int PASS_W = 16,
    localparam int NPIX   = IMG_W * IMG_H,
    localparam int ADDR_W = $clog2(NPIX),
    localparam int RW     = $clog2(IMG_H),
    localparam int CW     = $clog2(IMG_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_data,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic [PASS_W-1:0] pass_cnt
);
    typedef struct packed {
        logic [NPIX-1:0] frame;
        logic [NPIX-1:0] shadow;
        logic            rd_data;
    } buf_s;

    buf_s q, d;

    logic              scan, commit, phase;
    logic [RW-1:0]     row;
    logic [CW-1:0]     col;
    logic              center;
    logic [ADDR_W-1:0] ctr_idx;
    logic [7:0]        nb;
    logic              rule_del;
    logic              del_hit;

    thin_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H), .PASS_W(PASS_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .del_hit(del_hit),
        .scan(scan), .commit(commit), .busy(busy), .phase(phase),
        .row(row), .col(col), .done(done), .pass_cnt(pass_cnt)
    );

    thin_nbr_fetch #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_fetch (
        .frame(q.frame), .row(row), .col(col),
        .center(center), .ctr_idx(ctr_idx), .nb(nb)
    );

    thin_rule u_rule (
        .center(center), .nb(nb), .phase(phase), .del(rule_del)
    );

    assign del_hit = scan && rule_del;

    always_comb begin
        d = q;
        d.rd_data = q.frame[rd_addr];
        if (!busy && wr_en) begin
            d.frame[wr_addr]  = wr_data;
            d.shadow[wr_addr] = wr_data;
        end
        if (del_hit) d.shadow[ctr_idx] = 1'b1;
        if (commit)  d.frame = q.shadow;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{frame: '1, shadow: '1, rd_data: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign rd_data = q.rd_data;

    logic [NPIX-1:0] frame_q;
    logic [NPIX-1:0] shadow_q;
    assign frame_q  = q.frame;
    assign shadow_q = q.shadow;

    AST_NO_RIDGE_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($countones(frame_q) >= $past($countones(frame_q)))); // R8
    AST_SHADOW_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_q & ~shadow_q) == '0); // R6
    AST_FRAME_FROZEN_MID_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !commit) |=> $stable(frame_q)); // R10
    AST_IDLE_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !wr_en) |=> $stable(frame_q)); // R1

endmodule

// File: tb/thin_engine_test.sv
`timescale 1ns/1ps
module thin_engine_test;
    localparam int W    = 16;
    localparam int H    = 16;
    localparam int NPIX = W * H;
    localparam int AW   = $clog2(NPIX);
    localparam int PW   = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic          wr_data = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_data;
    logic          start = 1'b0;
    logic          busy, done;
    logic [PW-1:0] pass_cnt;

    always #2.5 clk = ~clk;

    thin_engine #(.IMG_W(W), .IMG_H(H), .PASS_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .start(start), .busy(busy), .done(done), .pass_cnt(pass_cnt)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit [NPIX-1:0] img, mdl, got;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    function automatic bit mp(input int r, input int c);
        if (r < 0 || r >= H || c < 0 || c >= W) return 1'b1;
        return mdl[r * W + c];
    endfunction

    function automatic bit may_del(input int r, input int c, input int ph);
        int dr[8] = '{-1, -1, 0, 1, 1, 1, 0, -1};
        int dc[8] = '{0, 1, 1, 1, 0, -1, -1, -1};
        bit n[8];
        int b = 0;
        int a = 0;
        bit dir;
        if (mp(r, c)) return 1'b0;
        for (int k = 0; k < 8; k++) n[k] = mp(r + dr[k], c + dc[k]);
        for (int k = 0; k < 8; k++) begin
            if (!n[k]) b++;
            if (n[k] && !n[(k + 1) % 8]) a++;
        end
        if (ph == 0) dir = (n[0] | n[2] | n[4]) & (n[2] | n[4] | n[6]);
        else         dir = (n[0] | n[2] | n[6]) & (n[0] | n[4] | n[6]);
        return (b >= 2) && (b <= 6) && (a == 1) && dir;
    endfunction

    task automatic model_run(output int pairs);
        bit any;
        bit [NPIX-1:0] nxt;
        pairs = 0;
        do begin
            pairs++;
            any = 0;
            for (int ph = 0; ph < 2; ph++) begin
                nxt = mdl;
                for (int r = 0; r < H; r++)
                    for (int c = 0; c < W; c++)
                        if (may_del(r, c, ph)) begin
                            nxt[r * W + c] = 1'b1;
                            any = 1;
                        end
                mdl = nxt;
            end
        end while (any);
    endtask

    // ---------------- port tasks ----------------
    task automatic load_image();
        for (int i = 0; i < NPIX; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = AW'(i); wr_data = img[i];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_all();
        for (int i = 0; i < NPIX; i++) begin
            @(negedge clk);
            rd_addr = AW'(i);
            @(negedge clk);
            got[i] = rd_data;
        end
    endtask

    task automatic cmp_image(input string req, input string what, input bit [NPIX-1:0] exp);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < NPIX; i++)
            if (got[i] !== exp[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        if (bad != 0)
            $display("FAIL %s %s first pixel %0d actual=%0d expected=%0d",
                     req, what, first, got[first], exp[first]);
        chk(bad == 0, req, {what, " mismatching pixels"}, bad, 0);
    endtask

    task automatic run_case(input string req, input string what, input bit poke,
                            input int poke_addr);
        int ep;
        int n = 0;
        mdl = img;
        model_run(ep);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy === 1'b1 && done === 1'b0, "R2", "busy after start", int'(busy), 1);
        if (poke) begin
            wr_en = 1'b1; wr_addr = AW'(poke_addr); wr_data = 1'b0;
            @(negedge clk);
            wr_en = 1'b0;
        end
        while (done !== 1'b1 && n < 40000) begin
            @(negedge clk);
            n++;
        end
        chk(done === 1'b1, req, {what, " done reached"}, int'(done), 1);
        read_all();
        cmp_image(req, what, mdl);
        chk(int'(pass_cnt) == ep, "R9", {what, " pair count"}, int'(pass_cnt), ep);
    endtask

    task automatic rect(input int r0, input int c0, input int h, input int w);
        for (int r = r0; r < r0 + h; r++)
            for (int c = c0; c < c0 + w; c++)
                if (r >= 0 && r < H && c >= 0 && c < W) img[r * W + c] = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(busy === 1'b0 && done === 1'b0, "R11", "idle after reset", int'(busy | done), 0);
        chk(pass_cnt === '0, "R11", "pass_cnt after reset", int'(pass_cnt), 0);
        read_all();
        cmp_image("R11", "reset frame all valley", '1);

        // R1 load and read back
        for (int i = 0; i < NPIX; i++) img[i] = 1'($urandom % 2);
        load_image();
        read_all();
        cmp_image("R1", "readback", img);

        // R12 blank image
        img = '1;
        load_image();
        run_case("R12", "blank frame", 0, 0);
        chk(int'(pass_cnt) == 1, "R12", "blank one pair", int'(pass_cnt), 1);

        // R3 isolated pixel and short stub survive
        img = '1;
        img[5 * W + 5] = 1'b0;
        img[10 * W + 3] = 1'b0;
        img[10 * W + 4] = 1'b0;
        load_image();
        run_case("R3", "isolated pixel and stub", 0, 0);
        chk(got[5 * W + 5] == 1'b0, "R3", "isolated pixel kept", int'(got[5 * W + 5]), 0);

        // R7 full ridge frame: corner pixel erased
        img = '0;
        load_image();
        run_case("R7", "full ridge frame", 0, 0);
        chk(got[0] == 1'b1, "R7", "corner erased", int'(got[0]), 1);

        // R4 / R5 thick bars
        img = '1;
        rect(3, 2, 3, 12);
        load_image();
        run_case("R4", "horizontal 3-wide bar", 0, 0);
        img = '1;
        rect(2, 6, 12, 3);
        load_image();
        run_case("R5", "vertical 3-wide bar", 0, 0);

        // R6 two-wide bar must not break apart
        img = '1;
        rect(7, 2, 2, 12);
        load_image();
        run_case("R6", "2-wide bar", 0, 0);

        // R10 write during busy ignored; R8 valley stays valley
        img = '1;
        rect(4, 4, 6, 6);
        load_image();
        run_case("R10", "write while busy", 1, 15 * W + 15);
        chk(got[15 * W + 15] == 1'b1, "R10", "poked pixel unchanged", int'(got[15 * W + 15]), 1);

        // random blobs
        for (int t = 0; t < 4; t++) begin
            img = '1;
            repeat (3 + $urandom % 4)
                rect(int'($urandom % H), int'($urandom % W),
                     2 + int'($urandom % 5), 2 + int'($urandom % 5));
            load_image();
            run_case("R8", "random blobs", 0, 0);
        end

        // R9 re-run on already thinned frame: one pair, unchanged
        img = got;
        run_case("R9", "rerun converged frame", 0, 0);
        chk(int'(pass_cnt) == 1, "R9", "rerun single pair", int'(pass_cnt), 1);
        cmp_image("R9", "rerun unchanged", img);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule